// File: doc/BRIEF.md
# Banked-Operand Accumulator Execute Unit

This block is the execute stage of a small 8-bit processor core. Each cycle it can accept one already-decoded command. The command carries an operation code, an 8-bit register offset, a window-select bit, a destination bit, a bit index, an 8-bit literal and, for register-to-register moves, two full 12-bit addresses. The unit turns the offset into a 12-bit address in a 4 KB data store, which is sixteen banks of 256 bytes. It reads the operand and applies the operation together with an accumulator register. It then writes the result to the accumulator or back to the store, and updates four condition flags.

A window-select bit of 0 picks a fixed window. That window joins the bottom 96 bytes of the store to the top 160 bytes. A window-select bit of 1 picks the 256-byte bank named by a 4-bit bank register. An unsigned 8x8 multiplier fills a 16-bit product register in the same pass. The unit has two stages. The store is read when the command is accepted, and the operation completes one edge later. Results are forwarded, so back-to-back commands always see the effect of the command before them.

Top module: `acc_exec_unit`

## Requirements
- R1: Reset clears the accumulator, the flags, the product register and the bank register to zero.
- R2: With window-select 0, an offset below 0x60 addresses 0x000+offset. An offset of 0x60 or above addresses 0xF00+offset.
- R3: With window-select 1, the address is {bank register, offset}. OP_SETBANK loads the bank register from the literal's low 4 bits, and the next command already uses the new value.
- R4: For operations that have a destination choice (OP_LDF, add, subtract, unary, register logic and rotate operations), destination bit 0 writes the result to the accumulator only. Destination bit 1 writes it to the addressed register only.
- R5: Flags are bit0 C, bit1 Z, bit2 N, bit3 OV. OP_ADD gives f+A, and OP_ADDC gives f+A+C. Both set C to the carry out, Z to result==0, N to result bit 7, and OV to signed overflow.
- R6: OP_SUB gives f−A, and OP_SUBB gives f−A−(1−C). C=1 means no borrow occurred. Z, N and OV are set as for an add.
- R7: OP_INC, OP_DEC, OP_NOT, OP_NEG, OP_LDF and the AND/OR/XOR operations (register or literal) update Z and N only. C and OV are kept.
- R8: OP_BCLR, OP_BSET and OP_BFLIP clear, set or invert bit b (0..7) of the addressed register and change no flag.
- R9: OP_ROLC and OP_RORC rotate through C, and C takes the bit that is shifted out. OP_ROL and OP_ROR rotate within the byte and keep C. All four update Z and N and keep OV.
- R10: OP_MULLIT and OP_MULF put the unsigned product of the accumulator and the literal (or the register) into the product register. The accumulator and the flags do not change.
- R11: OP_MOVE copies a byte from one full 12-bit address to another. OP_STW writes the accumulator to a register. Neither changes a flag.
- R12: A command sampled at edge k shows its result on the outputs after edge k+1. A command sampled at edge k+1 reads the value written by the command at edge k.
- R13: OP_LDLIT loads the literal and changes no flag. OP_ADDLIT adds the literal to the accumulator and sets the flags as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 5 | Operation code (acc_pkg::acc_op_e) |
| cmd_off | input | 8 | Register offset |
| cmd_banked | input | 1 | 0: fixed window, 1: bank register window |
| cmd_to_mem | input | 1 | Destination: 0 accumulator, 1 register |
| cmd_bit | input | 3 | Bit index for bit operations |
| cmd_lit | input | 8 | Literal operand |
| cmd_src | input | 12 | Source address for OP_MOVE |
| cmd_dst | input | 12 | Destination address for OP_MOVE |
| acc_out | output | 8 | Accumulator |
| flags_out | output | 4 | {OV, N, Z, C} |
| prod_out | output | 16 | Product register |
| bank_out | output | 4 | Bank register |

## Verification
Two functions can fall in the same cycle: the store write-back of one command and the operand read of the next command to the same address. The bench provokes this with uninterrupted chains: an accumulator store followed at once by three increments of that register, and a store, a move and a load issued back to back. It then judges the final value against a count done in the bench. If the collision were resolved wrongly, a stale byte would be visible. The arithmetic sweeps also issue their operations back to back with loads of the accumulator and the carry, so flag and accumulator forwarding are covered in every iteration.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 8;
  localparam int BANK_W = 4;

  typedef enum logic [4:0] {
    OP_NOP, OP_LDLIT, OP_ADDLIT, OP_ANDLIT, OP_ORLIT, OP_XORLIT, OP_MULLIT,
    OP_SETBANK, OP_STW, OP_LDF, OP_ADD, OP_ADDC, OP_SUB, OP_SUBB,
    OP_INC, OP_DEC, OP_NOT, OP_NEG, OP_AND, OP_OR, OP_XOR,
    OP_BCLR, OP_BSET, OP_BFLIP, OP_ROLC, OP_ROL, OP_RORC, OP_ROR,
    OP_MULF, OP_MOVE
  } acc_op_e;

  // packed: c is bit 0, z bit 1, n bit 2, ov bit 3
  typedef struct packed {
    logic ov;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_addr_map.sv
module acc_addr_map #(
  parameter int OFF_W    = 8,
  parameter int BANK_W   = 4,
  parameter int LOW_SPAN = 96,
  localparam int AW      = OFF_W + BANK_W
) (
  input  logic [OFF_W-1:0]  off,
  input  logic              banked,
  input  logic [BANK_W-1:0] bank,
  output logic [AW-1:0]     addr
);
  localparam logic [OFF_W-1:0] LOW_LIM = OFF_W'(LOW_SPAN);

  always_comb begin
    if (banked)              addr = {bank, off};
    else if (off < LOW_LIM)  addr = {{BANK_W{1'b0}}, off};
    else                     addr = {{BANK_W{1'b1}}, off};
  end

  // R2: fixed window never leaves the bottom or top bank
  always_comb begin
    if (!banked)
      a_r2_window_edges: assert (addr[AW-1:OFF_W] == {BANK_W{1'b0}} ||
                                 addr[AW-1:OFF_W] == {BANK_W{1'b1}});
  end
endmodule

// File: rtl/acc_dmem.sv
module acc_dmem #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu import acc_pkg::*; #(
  parameter int DW    = 8,
  parameter int BIT_W = $clog2(DW)
) (
  input  acc_op_e          op,
  input  logic [DW-1:0]    acc,
  input  logic [DW-1:0]    f,
  input  logic [DW-1:0]    lit,
  input  logic [BIT_W-1:0] bidx,
  input  logic             to_mem_req,
  input  flags_t           fin,
  output logic [DW-1:0]    res,
  output flags_t           fout,
  output logic [2*DW-1:0]  prod,
  output logic             wr_acc,
  output logic             wr_mem,
  output logic             wr_prod
);
  logic [DW-1:0] add_x, add_y, mask;
  logic          add_ci, add_ov;
  logic [DW:0]   sum;
  logic          upd_zn, upd_cv, upd_c, rot_c;

  always_comb begin
    add_x = f; add_y = acc; add_ci = 1'b0;
    case (op)
      OP_ADDLIT: begin add_x = acc; add_y = lit; end
      OP_ADDC:   add_ci = fin.c;
      OP_SUB:    begin add_y = ~acc; add_ci = 1'b1; end
      OP_SUBB:   begin add_y = ~acc; add_ci = fin.c; end
      default: ;
    endcase
  end

  assign sum    = {1'b0, add_x} + {1'b0, add_y} + {{DW{1'b0}}, add_ci};
  assign add_ov = (add_x[DW-1] == add_y[DW-1]) && (sum[DW-1] != add_x[DW-1]);
  assign mask   = {{(DW-1){1'b0}}, 1'b1} << bidx;

  always_comb begin
    res = f; fout = fin;
    prod = {{DW{1'b0}}, acc} * {{DW{1'b0}}, f};
    wr_acc = 1'b0; wr_mem = 1'b0; wr_prod = 1'b0;
    upd_zn = 1'b0; upd_cv = 1'b0; upd_c = 1'b0; rot_c = fin.c;
    case (op)
      OP_LDLIT:  begin res = lit; wr_acc = 1'b1; end
      OP_ADDLIT: begin res = sum[DW-1:0]; wr_acc = 1'b1; upd_zn = 1'b1; upd_cv = 1'b1; end
      OP_ANDLIT: begin res = acc & lit; wr_acc = 1'b1; upd_zn = 1'b1; end
      OP_ORLIT:  begin res = acc | lit; wr_acc = 1'b1; upd_zn = 1'b1; end
      OP_XORLIT: begin res = acc ^ lit; wr_acc = 1'b1; upd_zn = 1'b1; end
      OP_MULLIT: begin prod = {{DW{1'b0}}, acc} * {{DW{1'b0}}, lit}; wr_prod = 1'b1; end
      OP_MULF:   wr_prod = 1'b1;
      OP_STW:    begin res = acc; wr_mem = 1'b1; end
      OP_MOVE:   wr_mem = 1'b1;
      OP_LDF:    begin {wr_mem, wr_acc} = {to_mem_req, !to_mem_req}; upd_zn = 1'b1; end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
        res = sum[DW-1:0];
        {wr_mem, wr_acc} = {to_mem_req, !to_mem_req};
        upd_zn = 1'b1; upd_cv = 1'b1;
      end
      OP_INC, OP_DEC, OP_NOT, OP_NEG, OP_AND, OP_OR, OP_XOR: begin
        case (op)
          OP_INC:  res = f + DW'(1);
          OP_DEC:  res = f - DW'(1);
          OP_NOT:  res = ~f;
          OP_NEG:  res = {DW{1'b0}} - f;
          OP_AND:  res = f & acc;
          OP_OR:   res = f | acc;
          default: res = f ^ acc;
        endcase
        {wr_mem, wr_acc} = {to_mem_req, !to_mem_req};
        upd_zn = 1'b1;
      end
      OP_BCLR:  begin res = f & ~mask; wr_mem = 1'b1; end
      OP_BSET:  begin res = f | mask;  wr_mem = 1'b1; end
      OP_BFLIP: begin res = f ^ mask;  wr_mem = 1'b1; end
      OP_ROLC, OP_ROL, OP_RORC, OP_ROR: begin
        case (op)
          OP_ROLC: begin res = {f[DW-2:0], fin.c}; rot_c = f[DW-1]; upd_c = 1'b1; end
          OP_ROL:  res = {f[DW-2:0], f[DW-1]};
          OP_RORC: begin res = {fin.c, f[DW-1:1]}; rot_c = f[0]; upd_c = 1'b1; end
          default: res = {f[0], f[DW-1:1]};
        endcase
        {wr_mem, wr_acc} = {to_mem_req, !to_mem_req};
        upd_zn = 1'b1;
      end
      default: ;
    endcase
    if (upd_zn) begin
      fout.z = (res == {DW{1'b0}});
      fout.n = res[DW-1];
    end
    if (upd_cv) begin
      fout.c  = sum[DW];
      fout.ov = add_ov;
    end
    if (upd_c) fout.c = rot_c;
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit import acc_pkg::*; #(
  parameter int DW       = DATA_W,
  parameter int OW       = OFF_W,
  parameter int BW       = BANK_W,
  parameter int LOW_SPAN = 96,
  localparam int AW      = OW + BW,
  localparam int BIT_W   = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [4:0]       cmd_op,
  input  logic [OW-1:0]    cmd_off,
  input  logic             cmd_banked,
  input  logic             cmd_to_mem,
  input  logic [BIT_W-1:0] cmd_bit,
  input  logic [DW-1:0]    cmd_lit,
  input  logic [AW-1:0]    cmd_src,
  input  logic [AW-1:0]    cmd_dst,
  output logic [DW-1:0]    acc_out,
  output logic [3:0]       flags_out,
  output logic [2*DW-1:0]  prod_out,
  output logic [BW-1:0]    bank_out
);
  acc_op_e cop;
  assign cop = acc_op_e'(cmd_op);

  logic [BW-1:0]   bank_q;
  logic [DW-1:0]   acc_q;
  flags_t          flags_q;
  logic [2*DW-1:0] prod_q;

  // issue stage: address formation and store read
  logic [AW-1:0] win_addr, rd_addr, wr_addr;
  acc_addr_map #(.OFF_W(OW), .BANK_W(BW), .LOW_SPAN(LOW_SPAN)) u_map (
    .off(cmd_off), .banked(cmd_banked), .bank(bank_q), .addr(win_addr)
  );
  assign rd_addr = (cop == OP_MOVE) ? cmd_src : win_addr;
  assign wr_addr = (cop == OP_MOVE) ? cmd_dst : win_addr;

  logic             s1_vld, s1_to_mem;
  acc_op_e          s1_op;
  logic [AW-1:0]    s1_raddr, s1_waddr;
  logic [BIT_W-1:0] s1_bit;
  logic [DW-1:0]    s1_lit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      bank_q <= '0;
    end else begin
      s1_vld <= cmd_valid;
      if (cmd_valid && cop == OP_SETBANK) bank_q <= cmd_lit[BW-1:0];
    end
    s1_op     <= cop;
    s1_raddr  <= rd_addr;
    s1_waddr  <= wr_addr;
    s1_to_mem <= cmd_to_mem;
    s1_bit    <= cmd_bit;
    s1_lit    <= cmd_lit;
  end

  logic [DW-1:0]  mem_rdata, res, operand;
  logic           mem_we, wr_acc, wr_mem, wr_prod;
  flags_t         flags_nx;
  logic [2*DW-1:0] prod_nx;

  acc_dmem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .raddr(rd_addr), .rdata(mem_rdata),
    .we(mem_we), .waddr(s1_waddr), .wdata(res)
  );

  // store write in the same edge as this command's read: bypass it
  logic          fwd_vld;
  logic [AW-1:0] fwd_addr;
  logic [DW-1:0] fwd_data;
  assign operand = (fwd_vld && fwd_addr == s1_raddr) ? fwd_data : mem_rdata;

  acc_alu #(.DW(DW)) u_alu (
    .op(s1_op), .acc(acc_q), .f(operand), .lit(s1_lit), .bidx(s1_bit),
    .to_mem_req(s1_to_mem), .fin(flags_q), .res(res), .fout(flags_nx),
    .prod(prod_nx), .wr_acc(wr_acc), .wr_mem(wr_mem), .wr_prod(wr_prod)
  );
  assign mem_we = s1_vld & wr_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= '0;
      prod_q  <= '0;
      fwd_vld <= 1'b0;
    end else begin
      fwd_vld <= mem_we;
      if (s1_vld) begin
        flags_q <= flags_nx;
        if (wr_acc)  acc_q  <= res;
        if (wr_prod) prod_q <= prod_nx;
      end
    end
    fwd_addr <= s1_waddr;
    fwd_data <= res;
  end

  assign acc_out   = acc_q;
  assign flags_out = flags_q;
  assign prod_out  = prod_q;
  assign bank_out  = bank_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && flags_q == '0 && prod_q == '0 && bank_q == '0));
  a_r3_bank_load: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cop == OP_SETBANK) |=> bank_q == $past(cmd_lit[BW-1:0]));
  a_r5_add_carry_wrap: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_op == OP_ADDLIT) |=> flags_q.c == (acc_q < $past(acc_q)));
  a_r7_logic_zero: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_op inside {OP_ANDLIT, OP_ORLIT, OP_XORLIT}) |=> flags_q.z == (acc_q == '0));
  a_r8_flags_held: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_op inside {OP_BCLR, OP_BSET, OP_BFLIP, OP_MOVE, OP_STW, OP_LDLIT})
    |=> $stable(flags_q));
  a_r10_mul_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_op inside {OP_MULLIT, OP_MULF}) |=> ($stable(acc_q) && $stable(flags_q)));
  a_r10_prod_only_on_mul: assert property (@(posedge clk) disable iff (rst)
    !(s1_vld && s1_op inside {OP_MULLIT, OP_MULF}) |=> $stable(prod_q));
endmodule

// File: tb/sim_acc_exec_unit.sv
module sim_acc_exec_unit;
  import acc_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_banked = 1'b0, cmd_to_mem = 1'b0;
  logic [4:0]  cmd_op = '0;
  logic [7:0]  cmd_off = '0, cmd_lit = '0;
  logic [2:0]  cmd_bit = '0;
  logic [11:0] cmd_src = '0, cmd_dst = '0;
  logic [7:0]  acc_out;
  logic [3:0]  flags_out;
  logic [15:0] prod_out;
  logic [3:0]  bank_out;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_exec_unit u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_off(cmd_off),
    .cmd_banked(cmd_banked), .cmd_to_mem(cmd_to_mem), .cmd_bit(cmd_bit), .cmd_lit(cmd_lit),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .acc_out(acc_out), .flags_out(flags_out),
    .prod_out(prod_out), .bank_out(bank_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(acc_op_e op, logic [7:0] off, logic banked, logic to_mem,
                       logic [2:0] b, logic [7:0] lit, logic [11:0] src, logic [11:0] dst);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_off = off; cmd_banked = banked;
    cmd_to_mem = to_mem; cmd_bit = b; cmd_lit = lit; cmd_src = src; cmd_dst = dst;
  endtask

  task automatic lit_op(acc_op_e op, logic [7:0] lit);
    issue(op, 8'h00, 1'b0, 1'b0, 3'd0, lit, 12'h0, 12'h0);
  endtask

  task automatic reg_op(acc_op_e op, logic [7:0] off, logic to_mem);
    issue(op, off, 1'b0, to_mem, 3'd0, 8'h00, 12'h0, 12'h0);
  endtask

  task automatic flush();
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_carry(logic cin);
    lit_op(OP_LDLIT, cin ? 8'hFF : 8'h00);
    lit_op(OP_ADDLIT, 8'h01);
  endtask

  task automatic preset_flags();  // leaves {OV,N,Z,C} = 1011
    lit_op(OP_LDLIT, 8'h80);
    lit_op(OP_ADDLIT, 8'h80);
  endtask

  function automatic logic [7:0] pick(int k);
    case (k)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h0F;
      4: return 8'h10;  5: return 8'h3F;  6: return 8'h40;  7: return 8'h7E;
      8: return 8'h7F;  9: return 8'h80; 10: return 8'h81; 11: return 8'hC0;
      12: return 8'hFE; 13: return 8'hFF; 14: return 8'h55; default: return 8'hAA;
    endcase
  endfunction

  function automatic int sgn(logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic logic [3:0] fl(logic ov, logic [7:0] r, logic c);
    return {ov, r[7], (r == 8'h00), c};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", {acc_out, flags_out, prod_out, bank_out}, 32'h0);

    // R13/R5: literal add sweep
    for (int i = 0; i < 16; i++) for (int j = 0; j < 16; j++) begin
      logic [7:0] a, b; int s; logic [7:0] r;
      a = pick(i); b = pick(j);
      lit_op(OP_LDLIT, a); lit_op(OP_ADDLIT, b); flush();
      s = int'(a) + int'(b); r = s[7:0];
      check("R13 add literal", {acc_out, flags_out},
            {r, fl((sgn(a) + sgn(b) > 127) || (sgn(a) + sgn(b) < -128), r, s > 255)});
    end

    // R5/R6: add with carry and subtract with borrow against register
    for (int i = 0; i < 16; i++) for (int j = 0; j < 16; j += 3) for (int c = 0; c < 2; c++) begin
      logic [7:0] f, a, r; int s, ss;
      f = pick(i); a = pick(j);
      set_carry(c[0]); lit_op(OP_LDLIT, f); reg_op(OP_STW, 8'h10, 1'b1);
      lit_op(OP_LDLIT, a); reg_op(OP_ADDC, 8'h10, 1'b0); flush();
      s = int'(f) + int'(a) + c; r = s[7:0]; ss = sgn(f) + sgn(a) + c;
      check("R5 add with carry", {acc_out, flags_out}, {r, fl(ss > 127 || ss < -128, r, s > 255)});
      set_carry(c[0]); lit_op(OP_LDLIT, a); reg_op(OP_SUBB, 8'h10, 1'b0); flush();
      s = int'(f) - int'(a) - (1 - c); r = s[7:0]; ss = sgn(f) - sgn(a) - (1 - c);
      check("R6 subtract with borrow", {acc_out, flags_out}, {r, fl(ss > 127 || ss < -128, r, s >= 0)});
    end
    for (int i = 0; i < 16; i += 2) for (int j = 1; j < 16; j += 2) begin
      logic [7:0] f, a, r; int ss;
      f = pick(i); a = pick(j);
      lit_op(OP_LDLIT, f); reg_op(OP_STW, 8'h18, 1'b1);
      lit_op(OP_LDLIT, a); reg_op(OP_SUB, 8'h18, 1'b0); flush();
      r = f - a; ss = sgn(f) - sgn(a);
      check("R6 subtract", {acc_out, flags_out}, {r, fl(ss > 127 || ss < -128, r, f >= a)});
    end

    // R7: unary and logic keep C and OV
    for (int op = 0; op < 8; op++) for (int k = 0; k < 16; k++) begin
      logic [7:0] v, m, r; acc_op_e o;
      v = pick(k); m = pick(15 - k);
      case (op)
        0: begin o = OP_INC; r = v + 8'd1; end
        1: begin o = OP_DEC; r = v - 8'd1; end
        2: begin o = OP_NOT; r = ~v; end
        3: begin o = OP_NEG; r = 8'd0 - v; end
        4: begin o = OP_AND; r = v & m; end
        5: begin o = OP_OR;  r = v | m; end
        6: begin o = OP_XOR; r = v ^ m; end
        default: begin o = OP_LDF; r = v; end
      endcase
      preset_flags(); lit_op(OP_LDLIT, v); reg_op(OP_STW, 8'h11, 1'b1);
      lit_op(OP_LDLIT, m); reg_op(o, 8'h11, 1'b0); flush();
      check("R7 unary/logic flags", {acc_out, flags_out}, {r, fl(1'b1, r, 1'b1)});
    end
    lit_op(OP_LDLIT, 8'hF0); lit_op(OP_ANDLIT, 8'h0F); flush();
    check("R7 literal and to zero", {acc_out, flags_out[2:1]}, {8'h00, 2'b01});
    lit_op(OP_ORLIT, 8'h81); lit_op(OP_XORLIT, 8'h01); flush();
    check("R7 literal or/xor", {acc_out, flags_out[2:1]}, {8'h80, 2'b10});

    // R9: rotates
    for (int op = 0; op < 4; op++) for (int k = 0; k < 16; k++) for (int c = 0; c < 2; c++) begin
      logic [7:0] v, r; logic nc; acc_op_e o;
      v = pick(k);
      case (op)
        0: begin o = OP_ROLC; r = {v[6:0], c[0]}; nc = v[7]; end
        1: begin o = OP_ROL;  r = {v[6:0], v[7]}; nc = c[0]; end
        2: begin o = OP_RORC; r = {c[0], v[7:1]}; nc = v[0]; end
        default: begin o = OP_ROR; r = {v[0], v[7:1]}; nc = c[0]; end
      endcase
      set_carry(c[0]); lit_op(OP_LDLIT, v); reg_op(OP_STW, 8'h12, 1'b1);
      reg_op(o, 8'h12, 1'b0); flush();
      check("R9 rotate", {acc_out, flags_out}, {r, fl(1'b0, r, nc)});
    end

    // R8: bit operations, flags untouched
    for (int op = 0; op < 3; op++) for (int b = 0; b < 8; b++) begin
      logic [7:0] v, r; acc_op_e o;
      v = (b % 2 == 0) ? 8'h5A : 8'hA5;
      case (op)
        0: begin o = OP_BCLR; r = v & ~(8'd1 << b); end
        1: begin o = OP_BSET; r = v | (8'd1 << b); end
        default: begin o = OP_BFLIP; r = v ^ (8'd1 << b); end
      endcase
      preset_flags(); lit_op(OP_LDLIT, v); reg_op(OP_STW, 8'h13, 1'b1);
      issue(o, 8'h13, 1'b0, 1'b0, 3'(b), 8'h00, 12'h0, 12'h0); flush();
      check("R8 flags unchanged", 32'(flags_out), 32'hB);
      reg_op(OP_LDF, 8'h13, 1'b0); flush();
      check("R8 bit result", 32'(acc_out), 32'(r));
    end

    // R4: destination steering
    lit_op(OP_LDLIT, 8'h21); reg_op(OP_STW, 8'h14, 1'b1);
    lit_op(OP_LDLIT, 8'h05); reg_op(OP_ADD, 8'h14, 1'b1); flush();
    check("R4 dest=1 leaves accumulator", 32'(acc_out), 32'h05);
    reg_op(OP_LDF, 8'h14, 1'b0); flush();
    check("R4 dest=1 writes register", 32'(acc_out), 32'h26);
    reg_op(OP_DEC, 8'h14, 1'b0); reg_op(OP_LDF, 8'h14, 1'b0); flush();
    check("R4 dest=0 leaves register", 32'(acc_out), 32'h26);

    // R2/R3: fixed window against banked view
    for (int k = 0; k < 8; k++) begin
      logic [7:0] off;
      case (k)
        0: off = 8'h00; 1: off = 8'h01; 2: off = 8'h5F; 3: off = 8'h60;
        4: off = 8'h61; 5: off = 8'h80; 6: off = 8'hFE; default: off = 8'hFF;
      endcase
      lit_op(OP_LDLIT, off ^ 8'h3C); reg_op(OP_STW, off, 1'b1);
      lit_op(OP_SETBANK, (off < 8'h60) ? 8'h00 : 8'h0F); lit_op(OP_LDLIT, 8'h00);
      issue(OP_LDF, off, 1'b1, 1'b0, 3'd0, 8'h00, 12'h0, 12'h0); flush();
      check("R2 fixed window mapping", 32'(acc_out), 32'(off ^ 8'h3C));
    end
    lit_op(OP_LDLIT, 8'h11); reg_op(OP_STW, 8'h22, 1'b1);
    lit_op(OP_SETBANK, 8'hA7);
    lit_op(OP_LDLIT, 8'h9D);
    issue(OP_STW, 8'h22, 1'b1, 1'b1, 3'd0, 8'h00, 12'h0, 12'h0); flush();
    check("R3 bank register low bits", 32'(bank_out), 32'h7);
    reg_op(OP_LDF, 8'h22, 1'b0); flush();
    check("R3 banked write kept apart from window", 32'(acc_out), 32'h11);
    issue(OP_MOVE, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 12'h722, 12'h015);
    preset_flags(); flush();
    reg_op(OP_MOVE, 8'h00, 1'b0); flush();
    check("R11 move keeps flags", 32'(flags_out), 32'hB);
    reg_op(OP_LDF, 8'h15, 1'b0); flush();
    check("R11 move full address", 32'(acc_out), 32'h9D);

    // R10: multiply sweep, accumulator and flags held
    preset_flags();
    for (int i = 0; i < 16; i++) for (int j = 0; j < 16; j++) begin
      logic [7:0] a, b;
      a = pick(i); b = pick(j);
      lit_op(OP_LDLIT, a); lit_op(OP_MULLIT, b); flush();
      check("R10 multiply literal", {prod_out, acc_out, 4'h0, flags_out},
            {16'(int'(a) * int'(b)), a, 4'h0, 4'hB});
    end
    lit_op(OP_LDLIT, 8'hFD); reg_op(OP_STW, 8'h16, 1'b1);
    lit_op(OP_LDLIT, 8'hE3); reg_op(OP_MULF, 8'h16, 1'b0); flush();
    check("R10 multiply register", {prod_out, acc_out}, {16'(253 * 227), 8'hE3});

    // R12: latency and back-to-back collisions
    lit_op(OP_LDLIT, 8'h11); flush();
    lit_op(OP_LDLIT, 8'h77);
    @(negedge clk); cmd_valid = 1'b0;
    check("R12 not visible after one edge", 32'(acc_out), 32'h11);
    @(negedge clk);
    check("R12 visible after two edges", 32'(acc_out), 32'h77);
    lit_op(OP_LDLIT, 8'h03); reg_op(OP_STW, 8'h40, 1'b1);
    reg_op(OP_INC, 8'h40, 1'b1); reg_op(OP_INC, 8'h40, 1'b1); reg_op(OP_INC, 8'h40, 1'b0); flush();
    check("R12 chained increments forwarded", 32'(acc_out), 32'h06);
    lit_op(OP_LDLIT, 8'h6B); reg_op(OP_STW, 8'h41, 1'b1);
    issue(OP_MOVE, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 12'h041, 12'h042);
    lit_op(OP_LDLIT, 8'h00); reg_op(OP_LDF, 8'h42, 1'b0); flush();
    check("R12 store-move-load chain", 32'(acc_out), 32'h6B);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule